// File: doc/BRIEF.md
# Sub-cycle level-change word generator

This block drives the parallel side of an output serializer. The serializer takes one word per clock and shifts it out starting from bit 0, so bit 0 is the earliest sample in the cycle and the top bit is the latest. Upstream logic decides in which clock cycle a level change must happen. This block places the change at the exact bit inside that cycle's word. It does this by keeping the current line level and building each word from that level and the command that is pending.

Commands arrive on a bus qualified by a strobe. Each command carries an address, a data bit and a sub-cycle position. Address 0 is a level command: from the given position upward, the word takes the new level, and bits below the position keep the old level. Every later word carries the new level in all of its bits. Address 1 loads a separate output-enable flag from the data bit. Commands on any other address are dropped.

Top module: `tsword_gen`

## Requirements
- R1: While reset is held and after it is released, `ser_word` is all zero and `ser_oe` is 0 until a command takes effect.
- R2: A command sampled on a rising clock edge changes the outputs only after the next rising edge. In the cycle between those two edges, the outputs still show their previous values.
- R3: For a level command (address 0), the first word holds the new level (`cmd_data`) in every bit i with i >= `cmd_pos`. Every bit i < `cmd_pos` holds the level from before the command. For example, going high at position 3 from low gives 8'b11111000, and going low at position 4 from high gives 8'b00001111.
- R4: In every cycle without an applied level command, all bits of `ser_word` equal the held level. For example, the word after 8'b11111000 is 8'b11111111.
- R5: Position 0 switches the whole word at once: a change to 0 gives 8'h00 and the word stays 8'h00. Position 7 switches only bit 7: going high from low gives 8'b10000000.
- R6: A write to address 1 loads `ser_oe` from `cmd_data`, with the same latency as R2, and leaves `ser_word` unchanged.
- R7: A level command leaves `ser_oe` unchanged. A strobed command on address 2 or 3 changes neither output.
- R8: Level commands strobed in consecutive cycles are each applied in turn. Each one is built on the level left by the one before it.
- R9: A level command that repeats the held level produces a word with every bit at that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_addr | input | 2 | Command address: 0 = level, 1 = output enable |
| cmd_data | input | 1 | New level, or new output-enable value |
| cmd_pos | input | 3 | Bit position in the word where the level change starts |
| ser_word | output | 8 | Parallel word to the serializer, bit 0 earliest |
| ser_oe | output | 1 | Output-enable flag |

## Verification
Rising and falling changes are tried at every position from 0 to 7. This separates the bits above the position from those below it, and shows whether the old level fills the low bits. Commands that repeat the held level show that no spurious edge is produced. Back-to-back commands show whether each word is built on its predecessor's level. Writes to the output-enable address and to the unused addresses show that each output responds only to its own address.

// File: rtl/tsword_pkg.sv
package tsword_pkg;
  localparam int unsigned ADDR_LEVEL = 0;
  localparam int unsigned ADDR_OE    = 1;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_LEVEL = 2'd1,
    CMD_OE    = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/tsword_rst_sync.sv
module tsword_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/tsword_cmd_decode.sv
module tsword_cmd_decode
  import tsword_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned POS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_data,
  input  logic [POS_W-1:0]  cmd_pos,
  output cmd_kind_e         kind_q,
  output logic              data_q,
  output logic [POS_W-1:0]  pos_q
);
  cmd_kind_e        kind_d;
  logic             data_d;
  logic [POS_W-1:0] pos_d;
  logic             cap_en;

  always_comb begin
    kind_d = CMD_NONE;
    if (cmd_valid) begin
      if (cmd_addr == ADDR_W'(ADDR_LEVEL)) begin
        kind_d = CMD_LEVEL;
      end else if (cmd_addr == ADDR_W'(ADDR_OE)) begin
        kind_d = CMD_OE;
      end
    end
  end

  assign cap_en = cmd_valid;
  assign data_d = cap_en ? cmd_data : data_q;
  assign pos_d  = cap_en ? cmd_pos  : pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CMD_NONE;
      data_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      kind_q <= kind_d;
      data_q <= data_d;
      pos_q  <= pos_d;
    end
  end

  // R7: unused addresses never produce a pending command
  a_r7_other_addr_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_addr > ADDR_W'(ADDR_OE))) |=> (kind_q == CMD_NONE));

  // R2: no strobe, nothing pending next cycle
  a_r2_idle_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (kind_q == CMD_NONE));
endmodule

// File: rtl/tsword_word_build.sv
module tsword_word_build
  import tsword_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned POS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         kind_q,
  input  logic              data_q,
  input  logic [POS_W-1:0]  pos_q,
  output logic [WORD_W-1:0] ser_word,
  output logic              level_q
);
  logic              apply;
  logic [WORD_W-1:0] late_mask;
  logic [WORD_W-1:0] word_d;
  logic              level_d;

  assign apply = (kind_q == CMD_LEVEL);

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign late_mask[i] = (POS_W'(i) >= pos_q);
    assign word_d[i]    = (apply && late_mask[i]) ? data_q : level_q;
  end

  assign level_d = apply ? data_q : level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_word <= '0;
      level_q  <= 1'b0;
    end else begin
      ser_word <= word_d;
      level_q  <= level_d;
    end
  end

  // R4: without an applied command the word is uniform
  a_r4_uniform_word: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> (($countones(ser_word) == 0) || ($countones(ser_word) == WORD_W)));

  // R3: the latest bit always carries the new level
  a_r3_top_bit_new: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (ser_word[WORD_W-1] == $past(data_q)));

  // R3: the earliest bit keeps the old level when the change starts later
  a_r3_first_bit_old: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && (pos_q != '0)) |=> (ser_word[0] == $past(level_q)));

  // R5: position 0 switches the entire word
  a_r5_pos_zero_full: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && (pos_q == '0)) |=> (ser_word == {WORD_W{$past(data_q)}}));
endmodule

// File: rtl/tsword_oe_reg.sv
module tsword_oe_reg
  import tsword_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmd_kind_e kind_q,
  input  logic      data_q,
  output logic      ser_oe
);
  logic oe_en;
  logic oe_d;

  assign oe_en = (kind_q == CMD_OE);
  assign oe_d  = oe_en ? data_q : ser_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_oe <= 1'b0;
    end else begin
      ser_oe <= oe_d;
    end
  end

  // R6: output-enable write loads the data bit
  a_r6_oe_load: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == CMD_OE) |=> (ser_oe == $past(data_q)));

  // R7: other commands leave the flag alone
  a_r7_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q != CMD_OE) |=> $stable(ser_oe));
endmodule

// File: rtl/tsword_gen.sv
module tsword_gen
  import tsword_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_data,
  input  logic [POS_W-1:0]  cmd_pos,
  output logic [WORD_W-1:0] ser_word,
  output logic              ser_oe
);
  logic             rst_n_sync;
  cmd_kind_e        kind_q;
  logic             data_q;
  logic [POS_W-1:0] pos_q;
  logic             level_q;

  tsword_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tsword_cmd_decode #(
    .ADDR_W (ADDR_W),
    .POS_W  (POS_W)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_pos   (cmd_pos),
    .kind_q    (kind_q),
    .data_q    (data_q),
    .pos_q     (pos_q)
  );

  tsword_word_build #(
    .WORD_W (WORD_W),
    .POS_W  (POS_W)
  ) u_word (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .kind_q   (kind_q),
    .data_q   (data_q),
    .pos_q    (pos_q),
    .ser_word (ser_word),
    .level_q  (level_q)
  );

  tsword_oe_reg u_oe (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .kind_q (kind_q),
    .data_q (data_q),
    .ser_oe (ser_oe)
  );

  // R1: outputs are cleared while reset is held
  always_comb begin
    if (!rst_n_sync) begin
      a_r1_reset_clear: assert (ser_word == '0 && ser_oe == 1'b0 && level_q == 1'b0);
    end
  end
endmodule

// File: tb/tsword_gen_tb.sv
`timescale 1ns/1ps
module tsword_gen_tb;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_addr;
  logic       cmd_data;
  logic [2:0] cmd_pos;
  logic [7:0] ser_word;
  logic       ser_oe;

  int n_checks;
  int n_fail;
  string cur_req;

  // reference model state
  logic [7:0] m_word;
  logic       m_level;
  logic       m_oe;
  int         p_kind;
  logic       p_data;
  int         p_pos;

  tsword_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_pos   (cmd_pos),
    .ser_word  (ser_word),
    .ser_oe    (ser_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 8'h00; m_level = 1'b0; m_oe = 1'b0; p_kind = 0; p_data = 1'b0; p_pos = 0;
    end else begin
      if (p_kind == 1) begin
        for (int i = 0; i < 8; i++) m_word[i] = (i >= p_pos) ? p_data : m_level;
        m_level = p_data;
      end else begin
        m_word = {8{m_level}};
      end
      if (p_kind == 2) m_oe = p_data;
      p_kind = 0;
      if (cmd_valid && cmd_addr == 2'd0) p_kind = 1;
      if (cmd_valid && cmd_addr == 2'd1) p_kind = 2;
      p_data = cmd_data;
      p_pos  = int'(cmd_pos);
    end
  end

  task automatic check_word(input string req, input logic [7:0] exp);
    n_checks++;
    if (ser_word !== exp) begin
      n_fail++;
      $display("FAIL %s ser_word actual=%b expected=%b", req, ser_word, exp);
    end
  endtask

  task automatic check_oe(input string req, input logic exp);
    n_checks++;
    if (ser_oe !== exp) begin
      n_fail++;
      $display("FAIL %s ser_oe actual=%b expected=%b", req, ser_oe, exp);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check_word(cur_req, m_word);
      check_oe(cur_req, m_oe);
    end
  end

  // starts and ends on a falling edge; on return the command has been applied
  task automatic send(input logic [1:0] a, input logic d, input logic [2:0] p);
    logic [7:0] old_w;
    logic       old_oe;
    old_w = ser_word; old_oe = ser_oe;
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d; cmd_pos = p;
    @(negedge clk);
    check_word("R2", old_w);
    check_oe("R2", old_oe);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic lvl;
    logic [7:0] e;
    n_checks = 0; n_fail = 0; cur_req = "R1";
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = 2'd0; cmd_data = 1'b0; cmd_pos = 3'd0;
    repeat (3) @(negedge clk);
    check_word("R1", 8'h00); check_oe("R1", 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_word("R1", 8'h00); check_oe("R1", 1'b0);

    cur_req = "R6";
    send(2'd1, 1'b1, 3'd0);
    check_oe("R6", 1'b1); check_word("R6", 8'h00);

    cur_req = "R3";
    send(2'd0, 1'b1, 3'd3);
    check_word("R3", 8'b11111000); check_oe("R7", 1'b1);
    @(negedge clk); check_word("R4", 8'hFF);

    cur_req = "R5";
    send(2'd0, 1'b0, 3'd0);
    check_word("R5", 8'h00);
    @(negedge clk); check_word("R5", 8'h00);
    send(2'd0, 1'b1, 3'd7);
    check_word("R5", 8'b10000000);
    @(negedge clk); check_word("R4", 8'hFF);

    cur_req = "R3";
    send(2'd0, 1'b0, 3'd4);
    check_word("R3", 8'b00001111);
    @(negedge clk); check_word("R4", 8'h00);

    cur_req = "R7";
    send(2'd2, 1'b1, 3'd2);
    check_word("R7", 8'h00); check_oe("R7", 1'b1);
    @(negedge clk); check_word("R7", 8'h00);
    send(2'd3, 1'b0, 3'd0);
    check_word("R7", 8'h00); check_oe("R7", 1'b1);
    send(2'd1, 1'b0, 3'd5);
    check_oe("R6", 1'b0); check_word("R6", 8'h00);

    cur_req = "R9";
    send(2'd0, 1'b0, 3'd5);
    check_word("R9", 8'h00);
    send(2'd0, 1'b1, 3'd0);
    send(2'd0, 1'b1, 3'd2);
    check_word("R9", 8'hFF);
    send(2'd0, 1'b0, 3'd0);

    cur_req = "R8";
    cmd_valid = 1'b1; cmd_addr = 2'd0; cmd_data = 1'b1; cmd_pos = 3'd2;
    @(negedge clk); cmd_data = 1'b0; cmd_pos = 3'd5;
    @(negedge clk); cmd_data = 1'b1; cmd_pos = 3'd6;
    check_word("R8", 8'b11111100);
    @(negedge clk); cmd_valid = 1'b0;
    check_word("R8", 8'b00011111);
    @(negedge clk); check_word("R8", 8'b11000000);
    @(negedge clk); check_word("R8", 8'hFF);

    cur_req = "R3";
    lvl = 1'b1;
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 2; k++) begin
        for (int i = 0; i < 8; i++) e[i] = (i >= p) ? ~lvl : lvl;
        send(2'd0, ~lvl, 3'(p));
        check_word("R3", e);
        lvl = ~lvl;
        @(negedge clk); check_word("R4", {8{lvl}});
      end
    end

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule